// File: doc/BRIEF.md
# Microcoded March Self-Test Sequencer

This block runs a march-style self-test on a single-port RAM. A small read-only microcode store sits behind a program counter. Each microword makes one RAM access and sets how the address counter moves. It can also branch. When the branch is taken, the counter steps on to the next microword. When it is not taken, the counter steps back one, so a two-word loop body repeats until the address counter reaches the end of its sweep. The write data is built from a data background parameter. A microword can invert it or XOR it with the address parity. Read data is compared against the same pattern when the microword asks for a check.

The default microcode runs a 9N march. It writes the background ascending. It then runs two ascending read/write elements and two descending read/write elements, and the data polarity alternates between them. The sequencer then stops and holds. To run a different algorithm, pass a new image through the `PROG` parameter; no logic changes. The block starts on its own when reset is released. It assumes a RAM whose read data reflects `mem_addr` in the same cycle.

Top module: `mbist_useq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the program counter and `mem_addr` are 0 and `mem_we` and `test_done` are low.
- R2: A 10-bit microword carries these fields. Bit 9 is branch, bit 8 is address increment and bit 7 is address decrement. Bit 6 is address-parity XOR, bit 5 is invert and bit 4 is compare (0 = mask). Bit 3 is write (0 = read), bit 2 is clear, bit 1 is end, and bit 0 is spare. Microword k sits at `PROG[10k+9:10k]`.
- R3: A microword with the clear bit set loads 0 into the address counter at the next edge.
- R4: An increment microword adds 1 to the address and a decrement microword subtracts 1. Both wrap around: from 2^AW-1 to 0, or from 0 to 2^AW-1.
- R5: A branch microword moves the program counter forward when its limit is met and back by one otherwise. The limit is address 2^AW-1 for an increment, address 0 for a decrement, and always met if it neither increments nor decrements. A microword without the branch bit always moves forward.
- R6: `mem_wdata` equals the background. It is inverted bit-wise when the invert bit is set, and XORed with `mem_addr[0]` on every bit when the XOR bit is set.
- R7: `cmp_err` is high in a cycle exactly when the microword reads (write bit 0), has compare set, is not the end word, and `mem_rdata` differs from the R6 pattern. Masked reads never flag.
- R8: On a microword with the end bit set, `test_done` is high, `mem_we` is low, and the program counter and address hold for as long as reset stays high.
- R9: The default image performs a sequence of cycles. The first is a clear cycle. Next, for each address ascending, an idle cycle and then a write of D. Then two ascending elements run, each reading and then writing every address: read D/write ~D, followed by read ~D/write D. One idle cycle moves the address to the top. Two descending elements follow: read D/write ~D, then read ~D/write D. After that the sequencer sits in the end state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rdata | input | DW | RAM read data for `mem_addr` |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | DW | RAM write data |
| cmp_err | output | 1 | Compare mismatch in this cycle |
| test_done | output | 1 | Sequencer has reached its end microword |

## Verification
The bench builds two copies with an 8-word, 8-bit RAM (AW=3, DW=8). At that size, every element reaches both address limits, wraps, and hands over to the next element within about a hundred cycles. The first copy runs the default image with background 0xA5, whose odd bits differ from its inverse. The bench makes a second run of it with bit 0 of word 5 stuck low, which must give exactly two mismatches, both on the reads of D. The second copy uses background 0x0F and a short custom image. That image increments, clears in mid-program, and writes and reads a pattern that depends on address parity, which exercises the XOR field and the field layout.

// File: rtl/mbist_pkg.sv
// Shared microword layout and the default 9N march image.
// Assumes a fixed store of 16 microwords of 10 bits each.
package mbist_pkg;

    localparam int UW        = 10;
    localparam int PC_W      = 4;
    localparam int ROM_DEPTH = 1 << PC_W;

    // Bit 9 down to bit 0, in this order
    typedef struct packed {
        logic br;
        logic inc;
        logic dec;
        logic xo;
        logic inv;
        logic cmp;
        logic wr;
        logic clr;
        logic fin;
        logic spare;
    } uword_t;

    function automatic uword_t mk_uw(logic br, logic inc, logic dec, logic xo, logic inv,
                                     logic cmp, logic wr, logic clr, logic fin);
        uword_t w;
        w = '{br: br, inc: inc, dec: dec, xo: xo, inv: inv,
              cmp: cmp, wr: wr, clr: clr, fin: fin, spare: 1'b0};
        return w;
    endfunction

    // Default program: 9N march, end word fills the unused tail
    function automatic logic [ROM_DEPTH*UW-1:0] march9n_image();
        logic [ROM_DEPTH*UW-1:0] img;
        uword_t w;
        for (int i = 0; i < ROM_DEPTH; i++) begin
            case (i)
                0:  w = mk_uw(0,0,0,0,0,0,0,1,0); // clear address
                1:  w = mk_uw(0,0,0,0,0,0,0,0,0); // idle loop head
                2:  w = mk_uw(1,1,0,0,0,0,1,0,0); // write D, up
                3:  w = mk_uw(0,0,0,0,0,1,0,0,0); // read D
                4:  w = mk_uw(1,1,0,0,1,0,1,0,0); // write ~D, up
                5:  w = mk_uw(0,0,0,0,1,1,0,0,0); // read ~D
                6:  w = mk_uw(1,1,0,0,0,0,1,0,0); // write D, up
                7:  w = mk_uw(0,0,1,0,0,0,0,0,0); // move to top
                8:  w = mk_uw(0,0,0,0,0,1,0,0,0); // read D
                9:  w = mk_uw(1,0,1,0,1,0,1,0,0); // write ~D, down
                10: w = mk_uw(0,0,0,0,1,1,0,0,0); // read ~D
                11: w = mk_uw(1,0,1,0,0,0,1,0,0); // write D, down
                default: w = mk_uw(0,0,0,0,0,0,0,0,1); // end
            endcase
            img[i*UW +: UW] = w;
        end
        return img;
    endfunction

endpackage

// File: rtl/mbist_rom.sv
// Microcode store: returns the microword addressed by the program counter.
// Assumes the image is a packed vector, word k at bits [10k+9:10k].
module mbist_rom
    import mbist_pkg::*;
#(
    parameter logic [ROM_DEPTH*UW-1:0] PROG = march9n_image()
) (
    input  logic [PC_W-1:0] pc,
    output uword_t          uw
);

    // Select one word from the image
    always_comb begin
        uw = uword_t'(PROG[pc*UW +: UW]);
    end

endmodule

// File: rtl/mbist_pc.sv
// Program counter: steps forward, steps back on an unmet branch, holds on end.
// Assumes the limit flag is valid in the same cycle as the microword.
module mbist_pc
    import mbist_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br,
    input  logic            fin,
    input  logic            at_lim,
    output logic [PC_W-1:0] pc
);

    // Sequence the microcode
    always_ff @(posedge clk) begin
        if (!rst_n)             pc <= '0;
        else if (fin)           pc <= pc;
        else if (br && !at_lim) pc <= pc - 1'b1;
        else                    pc <= pc + 1'b1;
    end

endmodule

// File: rtl/mbist_addr.sv
// Address counter: clear, increment or decrement with wrap, and limit flag.
// Assumes clear takes priority over count and end freezes the count.
module mbist_addr #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    input  logic          fin,
    output logic [AW-1:0] addr,
    output logic          at_lim
);

    localparam logic [AW-1:0] TOP = '1;

    // Limit flag that ends the current sweep
    always_comb begin
        if (inc)      at_lim = (addr == TOP);
        else if (dec) at_lim = (addr == '0);
        else          at_lim = 1'b1;
    end

    // Move the address
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (fin) addr <= addr;
        else if (clr) addr <= '0;
        else if (inc) addr <= addr + 1'b1;
        else if (dec) addr <= addr - 1'b1;
    end

endmodule

// File: rtl/mbist_dpath.sv
// Data path: builds the pattern from the background and compares read data.
// Assumes read data is valid in the same cycle as the address.
module mbist_dpath #(
    parameter int             DW = 8,
    parameter logic [DW-1:0]  BG = '0
) (
    input  logic          inv,
    input  logic          xo,
    input  logic          chk,
    input  logic          addr_lsb,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] pat,
    output logic          err
);

    // Pattern for this address and microword
    always_comb begin
        pat = BG ^ {DW{inv}} ^ {DW{xo & addr_lsb}};
    end

    // Mismatch on a checked read
    always_comb begin
        err = chk && (rdata != pat);
    end

endmodule

// File: rtl/mbist_useq.sv
// Top level: microcoded march self-test sequencer for a single-port RAM.
// Assumes same-cycle read data and starts its program when reset is released.
module mbist_useq
    import mbist_pkg::*;
#(
    parameter int                       AW   = 3,
    parameter int                       DW   = 8,
    parameter logic [DW-1:0]            BG   = 8'hA5,
    parameter logic [ROM_DEPTH*UW-1:0]  PROG = march9n_image()
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          cmp_err,
    output logic          test_done
);

    logic [PC_W-1:0] pc_q;
    uword_t          uw_cur;
    logic            at_lim;
    logic            chk_rd;

    mbist_rom #(.PROG(PROG)) i_rom (
        .pc (pc_q),
        .uw (uw_cur)
    );

    mbist_pc i_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .br     (uw_cur.br),
        .fin    (uw_cur.fin),
        .at_lim (at_lim),
        .pc     (pc_q)
    );

    mbist_addr #(.AW(AW)) i_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (uw_cur.inc),
        .dec    (uw_cur.dec),
        .clr    (uw_cur.clr),
        .fin    (uw_cur.fin),
        .addr   (mem_addr),
        .at_lim (at_lim)
    );

    // Only a live read with compare set is checked
    always_comb begin
        chk_rd = uw_cur.cmp && !uw_cur.wr && !uw_cur.fin;
    end

    mbist_dpath #(.DW(DW), .BG(BG)) i_dp (
        .inv      (uw_cur.inv),
        .xo       (uw_cur.xo),
        .chk      (chk_rd),
        .addr_lsb (mem_addr[0]),
        .rdata    (mem_rdata),
        .pat      (mem_wdata),
        .err      (cmp_err)
    );

    // Strobe and end flag straight from the microword
    always_comb begin
        mem_we    = uw_cur.wr && !uw_cur.fin;
        test_done = uw_cur.fin;
    end

endmodule

// File: rtl/mbist_useq_chk.sv
// Checker for mbist_useq: sequencing, counting, compare and end behaviour.
// Assumes it is bound into the top and sees the live microword.
module mbist_useq_chk
    import mbist_pkg::*;
#(
    parameter int AW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [UW-1:0]   uw,
    input logic [PC_W-1:0] pc,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_we,
    input logic            cmp_err,
    input logic            test_done
);

    localparam logic [AW-1:0] TOP = '1;
    uword_t w;
    assign w = uword_t'(uw);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pc == '0) && (mem_addr == '0)); // R1
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (w.clr && !w.fin) |=> (mem_addr == '0)); // R3
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (w.inc && !w.clr && !w.fin) |=> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R4
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (w.dec && !w.inc && !w.clr && !w.fin) |=> (mem_addr == AW'($past(mem_addr) - 1'b1))); // R4
    AST_PC_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (w.br && w.inc && !w.fin && mem_addr != TOP) |=> (pc == PC_W'($past(pc) - 1'b1))); // R5
    AST_PC_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!w.br && !w.fin) |=> (pc == PC_W'($past(pc) + 1'b1))); // R5
    AST_ERR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |-> (!mem_we && w.cmp)); // R7
    AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |=> (test_done && $stable(pc) && $stable(mem_addr))); // R8
    AST_END_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |-> !mem_we); // R8

endmodule

bind mbist_useq mbist_useq_chk #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uw        (uw_cur),
    .pc        (pc_q),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .cmp_err   (cmp_err),
    .test_done (test_done)
);

// File: tb/test_mbist_useq.sv
module test_mbist_useq;

    localparam int AW = 3;
    localparam int DW = 8;
    localparam int N  = 1 << AW;
    localparam logic [7:0] BG_A = 8'hA5;
    localparam logic [7:0] BG_B = 8'h0F;

    // R2: bench-side encoder using the stated bit positions
    function automatic logic [9:0] enc(logic br, logic inc, logic dec, logic xo, logic inv,
                                       logic cmp, logic wr, logic clr, logic fin);
        return {br, inc, dec, xo, inv, cmp, wr, clr, fin, 1'b0};
    endfunction

    function automatic logic [159:0] alt_image();
        logic [159:0] img;
        for (int i = 0; i < 16; i++) begin
            case (i)
                0: img[i*10 +: 10] = enc(0,1,0,0,0,0,0,0,0); // step up once
                1: img[i*10 +: 10] = enc(0,0,0,0,0,0,0,1,0); // clear
                2: img[i*10 +: 10] = enc(0,0,0,0,0,0,0,0,0); // idle
                3: img[i*10 +: 10] = enc(1,1,0,1,0,0,1,0,0); // write parity pattern
                4: img[i*10 +: 10] = enc(0,0,0,0,0,0,0,0,0); // idle
                5: img[i*10 +: 10] = enc(1,1,0,1,0,1,0,0,0); // checked read, up
                default: img[i*10 +: 10] = enc(0,0,0,0,0,0,0,0,1);
            endcase
        end
        return img;
    endfunction

    localparam logic [159:0] ALT = alt_image();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] a_addr, b_addr;
    logic          a_we, b_we, a_err, b_err, a_done, b_done;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic [DW-1:0] ram_a [N];
    logic [DW-1:0] ram_b [N];
    logic          fault_on = 1'b0;

    mbist_useq #(.AW(AW), .DW(DW), .BG(BG_A)) i_mbist_useq (
        .clk(clk), .rst_n(rst_n), .mem_rdata(a_rdata), .mem_addr(a_addr),
        .mem_we(a_we), .mem_wdata(a_wdata), .cmp_err(a_err), .test_done(a_done));

    mbist_useq #(.AW(AW), .DW(DW), .BG(BG_B), .PROG(ALT)) i_alt (
        .clk(clk), .rst_n(rst_n), .mem_rdata(b_rdata), .mem_addr(b_addr),
        .mem_we(b_we), .mem_wdata(b_wdata), .cmp_err(b_err), .test_done(b_done));

    // RAM stand-ins, word 5 bit 0 of the first one may be stuck low
    always @(posedge clk) begin
        if (a_we) ram_a[a_addr] <= (fault_on && a_addr == 3'd5) ? (a_wdata & 8'hFE) : a_wdata;
        if (b_we) ram_b[b_addr] <= b_wdata;
    end
    assign a_rdata = ram_a[a_addr];
    assign b_rdata = ram_b[b_addr];

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          cmp;
        logic          done;
    } step_t;

    step_t q_a[$];
    step_t q_b[$];
    int tests = 0;
    int fails = 0;
    int a_errs = 0;
    bit finished = 1'b0;

    function automatic step_t st(logic we, int addr, logic [DW-1:0] d, logic cmp, logic done);
        step_t s;
        s.we = we; s.addr = AW'(addr); s.data = d; s.cmp = cmp; s.done = done;
        return s;
    endfunction

    // R9: expected cycle trace of the 9N march
    task automatic build_a();
        logic [DW-1:0] x;
        q_a = {};
        q_a.push_back(st(0, 0, '0, 0, 0));
        for (int a = 0; a < N; a++) begin
            q_a.push_back(st(0, a, '0, 0, 0));
            q_a.push_back(st(1, a, BG_A, 0, 0));
        end
        for (int e = 0; e < 2; e++) begin
            x = (e == 0) ? BG_A : ~BG_A;
            for (int a = 0; a < N; a++) begin
                q_a.push_back(st(0, a, x, 1, 0));
                q_a.push_back(st(1, a, ~x, 0, 0));
            end
        end
        q_a.push_back(st(0, 0, '0, 0, 0));
        for (int e = 0; e < 2; e++) begin
            x = (e == 0) ? BG_A : ~BG_A;
            for (int a = N - 1; a >= 0; a--) begin
                q_a.push_back(st(0, a, x, 1, 0));
                q_a.push_back(st(1, a, ~x, 0, 0));
            end
        end
        for (int k = 0; k < 4; k++) q_a.push_back(st(0, N - 1, '0, 0, 1));
    endtask

    // R2/R3/R6: expected trace of the alternate image
    task automatic build_b();
        q_b = {};
        q_b.push_back(st(0, 0, '0, 0, 0));
        q_b.push_back(st(0, 1, '0, 0, 0));
        for (int a = 0; a < N; a++) begin
            q_b.push_back(st(0, a, '0, 0, 0));
            q_b.push_back(st(1, a, BG_B ^ {DW{a[0]}}, 0, 0));
        end
        for (int a = 0; a < N; a++) begin
            q_b.push_back(st(0, a, '0, 0, 0));
            q_b.push_back(st(0, a, BG_B ^ {DW{a[0]}}, 1, 0));
        end
        for (int k = 0; k < 4; k++) q_b.push_back(st(0, 0, '0, 0, 1));
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, int cyc);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic compare(string who, step_t s, int cyc, logic we, logic [AW-1:0] addr,
                           logic [DW-1:0] wd, logic [DW-1:0] rd, logic err, logic done);
        logic exp_err;
        exp_err = s.cmp && (rd !== s.data);
        chk({who, " R4 R5 address"}, 32'(addr), 32'(s.addr), cyc);
        chk({who, " R9 write strobe"}, 32'(we), 32'(s.we), cyc);
        if (s.we) chk({who, " R6 write data"}, 32'(wd), 32'(s.data), cyc);
        chk({who, " R7 compare flag"}, 32'(err), 32'(exp_err), cyc);
        chk({who, " R8 end flag"}, 32'(done), 32'(s.done), cyc);
    endtask

    task automatic run_once(int run);
        int len;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1 reset address", 32'(a_addr), 0, -1);
        chk("R1 reset strobe", 32'(a_we), 0, -1);
        chk("R1 reset end flag", 32'(a_done), 0, -1);
        rst_n = 1'b1;
        #0.5;
        len = (q_a.size() > q_b.size()) ? q_a.size() : q_b.size();
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            if (k < q_a.size()) begin
                compare("main", q_a[k], k, a_we, a_addr, a_wdata, a_rdata, a_err, a_done);
                if (run == 1 && a_err === 1'b1) a_errs++;
            end
            if (k < q_b.size())
                compare("alt", q_b[k], k, b_we, b_addr, b_wdata, b_rdata, b_err, b_done);
        end
    endtask

    initial begin
        build_a();
        build_b();
        run_once(0);
        fault_on = 1'b1;
        run_once(1);
        // R7: stuck-low bit at word 5 shows on the two reads of D only
        chk("R7 mismatch count with fault", 32'(a_errs), 2, -1);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #50000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule